// File: doc/BRIEF.md
# PWM Pair Output Stage

This block is the last stage in front of the two pins of one PWM pair. It takes the high-side and low-side signals of a PWM generator and steers them onto the high pin and the low pin according to a two-bit pair mode. The modes are complementary, redundant, push-pull and true independent. Push-pull alternates between the pins on successive PWM cycles.

A stack of controls then acts on the steered signals. A software override can replace either pin, and its new setting can be held back until the next PWM cycle boundary. Fault and current-limit conditions force programmed states onto the pins. In the independent fault arrangement, the current-limit condition acts on the high pin and the fault condition acts on the low pin. After that selection the two results can be exchanged between the pins, and each pin has its own polarity. Finally, each pin can be handed to a plain GPIO value. All control values are treated as quasi-static configuration. Both pins come from registers, so any input reaches the pins one clock after it is sampled, and the override path adds one more clock.

Top module: `pwmpin_pair_out`

## Requirements
- R1: While `rst_n` is low, both pins are driven low; the held override is cleared (not enabled) and the push-pull phase returns to the high pin.
- R2: With `pair_mode` = 2'b00 (complementary) and nothing forced, the high pin carries `gen_hi` and the low pin carries its inverse, one clock after sampling.
- R3: With `pair_mode` = 2'b01 (redundant), both pins carry `gen_hi`.
- R4: With `pair_mode` = 2'b10 (push-pull), `gen_hi` goes to one pin while the other pin is inactive. The phase starts on the high pin and swaps at every clock edge where `cyc_start` is high.
- R5: With `pair_mode` = 2'b11 (true independent), the high pin carries `gen_hi` and the low pin carries `gen_lo`.
- R6: Override settings are taken from `ovr_en`/`ovr_data`, where bit 1 belongs to the high pin and bit 0 to the low pin. An enabled bit replaces that pin's generator state. With `ovr_sync` = 0, a new setting is captured at the next edge and reaches the pins one clock later.
- R7: With `ovr_sync` = 1, a new override setting is captured only at an edge where `cyc_start` is high; until then the previous setting stays in force.
- R8: With `flt_indep` = 0, an active `fault_act` forces `flt_data[1]` onto the high pin and `flt_data[0]` onto the low pin. This overrides the current limit, the override and the generator.
- R9: With `flt_indep` = 0 and no fault, an active `clim_act` forces `cl_data[1]`/`cl_data[0]` onto the high/low pin. This overrides the override and the generator.
- R10: With `flt_indep` = 1, `clim_act` forces `flt_data[1]` onto the high pin only and `fault_act` forces `flt_data[0]` onto the low pin only; `cl_data` has no effect.
- R11: All selected values are active states. A set polarity bit (`pol[1]` high pin, `pol[0]` low pin) makes that pin active-low, so the pin level is the inverted state.
- R12: With `swap` = 1, the state selected for the high side drives the low pin and the state selected for the low side drives the high pin. The exchange happens before polarity, so each pin keeps its own polarity bit.
- R13: When an ownership bit (`own[1]` high, `own[0]` low) is 0, that pin takes the matching `gpio_val` bit unchanged, with no polarity applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_hi | input | 1 | Generator high-side signal |
| gen_lo | input | 1 | Generator low-side signal |
| cyc_start | input | 1 | One-clock strobe at the PWM cycle boundary |
| fault_act | input | 1 | Fault condition active |
| clim_act | input | 1 | Current-limit condition active |
| pair_mode | input | 2 | Pair mode: 00 compl., 01 redundant, 10 push-pull, 11 independent |
| ovr_en | input | 2 | Override enable, bit 1 high pin, bit 0 low pin |
| ovr_data | input | 2 | Override active state, bit 1 high pin, bit 0 low pin |
| ovr_sync | input | 1 | Hold override changes until the cycle boundary |
| flt_data | input | 2 | Forced states used by fault (and by current limit in independent fault mode) |
| cl_data | input | 2 | Forced states for current limit in normal fault mode |
| flt_indep | input | 1 | Independent fault mode select |
| pol | input | 2 | Per-pin active-low select, bit 1 high pin |
| swap | input | 1 | Exchange high and low results |
| own | input | 2 | Per-pin PWM ownership; 0 hands the pin to GPIO |
| gpio_val | input | 2 | GPIO levels, bit 1 high pin |
| pin_hi | output | 1 | High pin level |
| pin_lo | output | 1 | Low pin level |

## Verification
The hardest situation to reach is a synchronised override change that waits across several clocks. During that wait the push-pull phase is also moving, so the bench must know which override setting and which phase apply at each edge. The stimulus holds `ovr_sync` high and changes `ovr_data` between boundary strobes. It then pulses `cyc_start` and follows the pins before, at and after the capture edge. A second hard case stacks fault, current limit, override, swap and inverted polarity in the same cycle, in both fault arrangements. This shows the priority order and the place where the exchange happens.

// File: rtl/pwmpin_pkg.sv
// Package: shared types and constants for the PWM pair output stage.
// Assumes pin vectors are indexed with the high pin at PIN_HI and the low pin at PIN_LO.
package pwmpin_pkg;
    localparam int PIN_N  = 2;
    localparam int PIN_HI = 1;
    localparam int PIN_LO = 0;

    typedef enum logic [1:0] {
        PM_COMPL    = 2'b00,
        PM_REDUN    = 2'b01,
        PM_PUSHPULL = 2'b10,
        PM_INDEP    = 2'b11
    } pair_mode_e;
endpackage

// File: rtl/pwmpin_steer.sv
// Steering: maps the generator high/low signals onto the two pin states by pair mode.
// Holds the push-pull phase register, which toggles on each cycle-boundary strobe.
// Assumes cyc_start is a single-clock strobe.
module pwmpin_steer
    import pwmpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cyc_start,
    input  logic             gen_hi,
    input  logic             gen_lo,
    output logic [PIN_N-1:0] mapped
);
    logic phase_q; // 0: push-pull drives high pin, 1: low pin

    // Push-pull phase: alternate pins on every PWM cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_q <= 1'b0;
        else if (cyc_start) phase_q <= ~phase_q;
    end

    // Mode mapping of the generator signals onto the pin states.
    always_comb begin
        mapped = '0;
        unique case (pair_mode_e'(mode))
            PM_COMPL: begin
                mapped[PIN_HI] = gen_hi;
                mapped[PIN_LO] = ~gen_hi;
            end
            PM_REDUN: begin
                mapped[PIN_HI] = gen_hi;
                mapped[PIN_LO] = gen_hi;
            end
            PM_PUSHPULL: begin
                mapped[PIN_HI] = phase_q ? 1'b0 : gen_hi;
                mapped[PIN_LO] = phase_q ? gen_hi : 1'b0;
            end
            default: begin
                mapped[PIN_HI] = gen_hi;
                mapped[PIN_LO] = gen_lo;
            end
        endcase
    end

    // R4: the phase flips at every boundary strobe
    assert_pp_phase_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (phase_q != $past(phase_q)));
    // R4: without a strobe the phase holds
    assert_pp_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(phase_q));
endmodule

// File: rtl/pwmpin_ovr_hold.sv
// Override holding register: captures override enable and data either every clock
// or only at the PWM cycle boundary when synchronised updates are selected.
// Assumes ovr_sync is static while an update is pending.
module pwmpin_ovr_hold
    import pwmpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             cyc_start,
    input  logic [PIN_N-1:0] en_in,
    input  logic [PIN_N-1:0] dat_in,
    output logic [PIN_N-1:0] en_q,
    output logic [PIN_N-1:0] dat_q
);
    logic take;
    assign take = !sync || cyc_start;

    // Capture the override setting on an allowed edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dat_q <= '0;
        end else if (take) begin
            en_q  <= en_in;
            dat_q <= dat_in;
        end
    end

    // R7: a synchronised setting does not move between boundaries
    assert_ovr_sync_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !cyc_start) |=> ($stable(en_q) && $stable(dat_q)));
    // R6: an unsynchronised setting is held one clock after it is presented
    assert_ovr_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (en_q == $past(en_in) && dat_q == $past(dat_in)));
endmodule

// File: rtl/pwmpin_force.sv
// Per-pin state selection: fault, then current limit, then override, then generator.
// IS_HI picks which pin this instance serves; that matters only in independent fault mode,
// where the high pin follows the current limit and the low pin follows the fault.
module pwmpin_force #(
    parameter bit IS_HI = 1'b1
) (
    input  logic fault_act,
    input  logic clim_act,
    input  logic indep,
    input  logic flt_bit,
    input  logic cl_bit,
    input  logic ovr_en,
    input  logic ovr_bit,
    input  logic gen_bit,
    output logic state
);
    logic forced;
    logic forced_val;

    // Forced-state decision for this pin.
    always_comb begin
        forced     = 1'b0;
        forced_val = 1'b0;
        if (indep) begin
            if (IS_HI && clim_act) begin
                forced     = 1'b1;
                forced_val = flt_bit;
            end else if (!IS_HI && fault_act) begin
                forced     = 1'b1;
                forced_val = flt_bit;
            end
        end else if (fault_act) begin
            forced     = 1'b1;
            forced_val = flt_bit;
        end else if (clim_act) begin
            forced     = 1'b1;
            forced_val = cl_bit;
        end
    end

    // Final active state: forced value, else override, else generator.
    always_comb begin
        if (forced)      state = forced_val;
        else if (ovr_en) state = ovr_bit;
        else             state = gen_bit;
    end
endmodule

// File: rtl/pwmpin_pair_out.sv
// PWM pair output stage top: steering, override hold, per-pin forcing, swap,
// polarity, GPIO handover and the registered pins.
// Assumes control inputs are quasi-static and already synchronous to clk.
module pwmpin_pair_out
    import pwmpin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_hi,
    input  logic       gen_lo,
    input  logic       cyc_start,
    input  logic       fault_act,
    input  logic       clim_act,
    input  logic [1:0] pair_mode,
    input  logic [1:0] ovr_en,
    input  logic [1:0] ovr_data,
    input  logic       ovr_sync,
    input  logic [1:0] flt_data,
    input  logic [1:0] cl_data,
    input  logic       flt_indep,
    input  logic [1:0] pol,
    input  logic       swap,
    input  logic [1:0] own,
    input  logic [1:0] gpio_val,
    output logic       pin_hi,
    output logic       pin_lo
);
    logic [PIN_N-1:0] mapped;
    logic [PIN_N-1:0] ovr_en_q;
    logic [PIN_N-1:0] ovr_dat_q;
    logic [PIN_N-1:0] sel;
    logic [PIN_N-1:0] swapped;
    logic [PIN_N-1:0] level;
    logic [PIN_N-1:0] pin_d;
    logic [PIN_N-1:0] pin_q;

    pwmpin_steer u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (pair_mode),
        .cyc_start (cyc_start),
        .gen_hi    (gen_hi),
        .gen_lo    (gen_lo),
        .mapped    (mapped)
    );

    pwmpin_ovr_hold u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (ovr_sync),
        .cyc_start (cyc_start),
        .en_in     (ovr_en),
        .dat_in    (ovr_data),
        .en_q      (ovr_en_q),
        .dat_q     (ovr_dat_q)
    );

    for (genvar gi = 0; gi < PIN_N; gi++) begin : g_pin
        pwmpin_force #(.IS_HI(gi == PIN_HI)) u_force (
            .fault_act (fault_act),
            .clim_act  (clim_act),
            .indep     (flt_indep),
            .flt_bit   (flt_data[gi]),
            .cl_bit    (cl_data[gi]),
            .ovr_en    (ovr_en_q[gi]),
            .ovr_bit   (ovr_dat_q[gi]),
            .gen_bit   (mapped[gi]),
            .state     (sel[gi])
        );

        // Swap, then polarity, then GPIO handover for this pin.
        always_comb begin
            swapped[gi] = swap ? sel[PIN_N-1-gi] : sel[gi];
            level[gi]   = swapped[gi] ^ pol[gi];
            pin_d[gi]   = own[gi] ? level[gi] : gpio_val[gi];
        end
    end

    // Pin register: pins are low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign pin_hi = pin_q[PIN_HI];
    assign pin_lo = pin_q[PIN_LO];

    // R13: a pin handed to GPIO shows the GPIO value raw
    assert_gpio_hi_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !own[1] |=> (pin_hi == $past(gpio_val[1])));
    assert_gpio_lo_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !own[0] |=> (pin_lo == $past(gpio_val[0])));
    // R8: normal-mode fault forces both pins
    assert_fault_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_indep && fault_act && !swap && own == 2'b11)
        |=> ({pin_hi, pin_lo} == $past(flt_data ^ pol)));
    // R10: independent mode, current limit drives the high pin from fault data
    assert_indep_clim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_indep && clim_act && !swap && own[1])
        |=> (pin_hi == $past(flt_data[1] ^ pol[1])));
    // R1: pins are low after a reset clock
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!pin_hi && !pin_lo));
endmodule

// File: tb/pwmpin_pair_out_tb.sv
// Scoreboard bench: the driver applies inputs at the falling edge and queues the
// expected pins for the next rising edge; the monitor compares them just after it.
module pwmpin_pair_out_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_hi = 0, gen_lo = 0, cyc_start = 0, fault_act = 0, clim_act = 0;
    logic [1:0] pair_mode = 2'b00, ovr_en = 2'b00, ovr_data = 2'b00;
    logic       ovr_sync = 0;
    logic [1:0] flt_data = 2'b00, cl_data = 2'b00;
    logic       flt_indep = 0;
    logic [1:0] pol = 2'b00;
    logic       swap = 0;
    logic [1:0] own = 2'b11, gpio_val = 2'b00;
    logic       pin_hi, pin_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench-side model state
    logic       m_phase = 0;
    logic [1:0] m_oe = 0, m_od = 0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk; // 125 MHz

    pwmpin_pair_out dut_i (
        .clk(clk), .rst_n(rst_n), .gen_hi(gen_hi), .gen_lo(gen_lo),
        .cyc_start(cyc_start), .fault_act(fault_act), .clim_act(clim_act),
        .pair_mode(pair_mode), .ovr_en(ovr_en), .ovr_data(ovr_data),
        .ovr_sync(ovr_sync), .flt_data(flt_data), .cl_data(cl_data),
        .flt_indep(flt_indep), .pol(pol), .swap(swap), .own(own),
        .gpio_val(gpio_val), .pin_hi(pin_hi), .pin_lo(pin_lo)
    );

    // Expected pins {hi,lo} after the coming edge, from the requirements.
    function automatic logic [1:0] model_out();
        logic [1:0] g, s, w, l, r;
        case (pair_mode)
            2'b00: g = {gen_hi, ~gen_hi};
            2'b01: g = {gen_hi, gen_hi};
            2'b10: g = m_phase ? {1'b0, gen_hi} : {gen_hi, 1'b0};
            default: g = {gen_hi, gen_lo};
        endcase
        for (int i = 0; i < 2; i++) begin
            s[i] = m_oe[i] ? m_od[i] : g[i];
            if (flt_indep) begin
                if (i == 1 && clim_act)  s[i] = flt_data[1];
                if (i == 0 && fault_act) s[i] = flt_data[0];
            end else begin
                if (clim_act)  s[i] = cl_data[i];
                if (fault_act) s[i] = flt_data[i];
            end
        end
        w = swap ? {s[0], s[1]} : s;
        l = w ^ pol;
        for (int i = 0; i < 2; i++) r[i] = own[i] ? l[i] : gpio_val[i];
        return r;
    endfunction

    // Driver: inputs are already set; queue expectation, advance model, wait one clock.
    task automatic tick(input string tag);
        item_t it;
        it.exp = model_out();
        it.tag = tag;
        sb_q.push_back(it);
        if (!ovr_sync || cyc_start) begin
            m_oe = ovr_en;
            m_od = ovr_data;
        end
        if (cyc_start) m_phase = ~m_phase;
        @(negedge clk);
    endtask

    // Monitor: compare just after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if ({pin_hi, pin_lo} !== it.exp) begin
                n_fail++;
                $display("FAIL %s: pins actual=%b expected=%b", it.tag, {pin_hi, pin_lo}, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        gen_hi = 1; own = 2'b11; pol = 2'b00;
        repeat (3) @(negedge clk);
        n_checks++;
        if ({pin_hi, pin_lo} !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: reset pins actual=%b expected=00", {pin_hi, pin_lo});
        end
        rst_n = 1;
        // R2 complementary
        pair_mode = 2'b00; gen_hi = 1; tick("R2");
        gen_hi = 0; tick("R2");
        gen_hi = 1; tick("R2");
        // R3 redundant
        pair_mode = 2'b01; gen_hi = 1; gen_lo = 0; tick("R3");
        gen_hi = 0; gen_lo = 1; tick("R3");
        // R5 independent
        pair_mode = 2'b11; gen_hi = 1; gen_lo = 0; tick("R5");
        gen_hi = 0; gen_lo = 1; tick("R5");
        // R4 push-pull across boundaries (R1 phase starts on high pin)
        pair_mode = 2'b10; gen_hi = 1; tick("R4_R1");
        cyc_start = 1; tick("R4");
        cyc_start = 0; tick("R4");
        tick("R4");
        cyc_start = 1; tick("R4");
        cyc_start = 0; tick("R4");
        // R6 unsynchronised override
        pair_mode = 2'b00; gen_hi = 1;
        ovr_en = 2'b11; ovr_data = 2'b01; tick("R6");
        tick("R6");
        ovr_en = 2'b10; ovr_data = 2'b00; tick("R6");
        tick("R6");
        // R7 synchronised override with push-pull running
        pair_mode = 2'b10; ovr_sync = 1; ovr_en = 2'b01; ovr_data = 2'b01; tick("R7");
        tick("R7");
        tick("R7");
        cyc_start = 1; tick("R7");
        cyc_start = 0; ovr_data = 2'b00; tick("R7");
        tick("R7");
        cyc_start = 1; tick("R7");
        cyc_start = 0; ovr_sync = 0; ovr_en = 2'b00; tick("R7");
        tick("R7");
        // R8 normal fault over current limit and override
        pair_mode = 2'b11; gen_hi = 1; gen_lo = 1;
        ovr_en = 2'b11; ovr_data = 2'b11; tick("R8");
        fault_act = 1; clim_act = 1; flt_data = 2'b01; cl_data = 2'b10; tick("R8");
        tick("R8");
        // R9 current limit alone
        fault_act = 0; tick("R9");
        cl_data = 2'b01; tick("R9");
        // R10 independent fault mode
        flt_indep = 1; ovr_en = 2'b00; gen_hi = 0; gen_lo = 0;
        clim_act = 1; fault_act = 0; flt_data = 2'b10; cl_data = 2'b01; tick("R10");
        clim_act = 0; fault_act = 1; flt_data = 2'b01; gen_hi = 1; tick("R10");
        clim_act = 1; fault_act = 1; flt_data = 2'b00; cl_data = 2'b11; gen_lo = 1; tick("R10");
        clim_act = 0; fault_act = 0; flt_indep = 0; tick("R10");
        // R11 polarity
        pair_mode = 2'b11; gen_hi = 1; gen_lo = 0; pol = 2'b11; tick("R11");
        pol = 2'b10; tick("R11");
        pol = 2'b01; gen_hi = 0; gen_lo = 0; tick("R11");
        // R12 swap before polarity
        pol = 2'b00; swap = 1; gen_hi = 1; gen_lo = 0; tick("R12");
        pol = 2'b01; tick("R12");
        fault_act = 1; flt_data = 2'b10; pol = 2'b10; tick("R12");
        fault_act = 0; swap = 0; pol = 2'b00; tick("R12");
        // R13 GPIO handover ignores polarity
        own = 2'b00; gpio_val = 2'b10; pol = 2'b11; tick("R13");
        own = 2'b01; gpio_val = 2'b01; tick("R13");
        own = 2'b10; gpio_val = 2'b10; fault_act = 1; flt_data = 2'b11; tick("R13");
        fault_act = 0; own = 2'b11; pol = 2'b00; tick("R13");
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule